// File: doc/BRIEF.md
# Circular Return-Address Stack

This block holds the return addresses that a processor sequencer saves on a subroutine call or when it takes an interrupt. It keeps eight entries of 13 bits each. A push strobe stores the presented address. A pop strobe discards the newest entry. The top-of-stack output always shows the entry that the next pop would hand back. The sequencer raises push for calls and interrupt branches, and raises pop for the three kinds of return. It reads the return address from the top-of-stack output in the same cycle that it pulses pop.

The index into the storage is private to the block, and nothing outside can read or load it. Neither a full nor an empty condition is flagged. The index wraps in both directions. A ninth push without pops therefore replaces the oldest saved address. Popping past the bottom yields whatever stale entry the wrapped index reaches.

Top module: `ret_stack`

## Requirements
- R1: A synchronous active-high reset sets the internal index to slot 0 and leaves the stored entries unchanged. Right after reset, the top-of-stack output shows the content of slot DEPTH-1 as it was before reset.
- R2: A push writes push_addr_i into the slot under the index and then advances the index by one. From the next cycle, tos_o equals the pushed address.
- R3: The index wraps from DEPTH-1 to 0 on a push. With the default depth of 8, the ninth push in a row overwrites the first pushed value and the tenth overwrites the second.
- R4: A pop moves the index back by one. From the next cycle, tos_o shows the entry that was pushed before the one just removed.
- R5: A pop at index 0 wraps the index to DEPTH-1 without any indication. Later pops keep returning stale entries in descending slot order.
- R6: When push and pop are asserted in the same cycle, only the push takes effect.
- R7: In a cycle with neither strobe, the index and all entries hold, so tos_o keeps its value.
- R8: tos_o is always the entry in the slot just below the index, modulo DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Save push_addr_i as the new top entry |
| pop_i | input | 1 | Discard the top entry |
| push_addr_i | input | 13 | Return address to be saved |
| tos_o | output | 13 | Newest saved return address |

## Verification
An index that drifts shows up at tos_o in the cycle right after the offending strobe: the output then presents a neighbouring slot instead of the address just pushed or the one below it. A write that lands in the wrong slot stays hidden until the pops unwind down to that slot. For that reason the bench runs long push and pop chains, full wrap-arounds and underflows, so that every slot is read back. Stale data after underflow, and data kept across reset, are predicted from the bench's own model of all eight slots.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;

    localparam int unsigned RS_WIDTH = 13;
    localparam int unsigned RS_DEPTH = 8;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } stack_op_e;

    // push wins over pop
    function automatic stack_op_e decode_op(input logic push, input logic pop);
        if (push)     return OP_PUSH;
        else if (pop) return OP_POP;
        else          return OP_HOLD;
    endfunction

    function automatic int unsigned wrap_inc(input int unsigned idx, input int unsigned depth);
        return (idx == depth - 1) ? 0 : idx + 1;
    endfunction

    function automatic int unsigned wrap_dec(input int unsigned idx, input int unsigned depth);
        return (idx == 0) ? depth - 1 : idx - 1;
    endfunction

endpackage

// File: rtl/ret_stack_ctrl.sv
module ret_stack_ctrl
    import ret_stack_pkg::*;
#(
    parameter int unsigned DEPTH = RS_DEPTH,
    localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic          pop_i,
    output logic          wr_en_o,
    output logic [PW-1:0] wr_idx_o,
    output logic [PW-1:0] rd_idx_o,
    output logic [PW-1:0] ptr_o
);

    stack_op_e     op;
    logic [PW-1:0] ptr_q;
    logic [PW-1:0] ptr_d;

    assign op = decode_op(push_i, pop_i);

    always_comb begin
        unique case (op)
            OP_PUSH: ptr_d = PW'(wrap_inc(int'(ptr_q), DEPTH));
            OP_POP:  ptr_d = PW'(wrap_dec(int'(ptr_q), DEPTH));
            default: ptr_d = ptr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end

    assign wr_en_o  = (op == OP_PUSH);
    assign wr_idx_o = ptr_q;
    assign rd_idx_o = PW'(wrap_dec(int'(ptr_q), DEPTH));
    assign ptr_o    = ptr_q;

endmodule

// File: rtl/ret_stack_store.sv
module ret_stack_store #(
    parameter int unsigned WIDTH = 13,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             wr_en_i,
    input  logic [PW-1:0]    wr_idx_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic [PW-1:0]    rd_idx_i,
    output logic [WIDTH-1:0] rd_data_o
);

    logic [WIDTH-1:0] slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [WIDTH-1:0] q;
        // entries are not cleared by reset
        always_ff @(posedge clk) begin
            if (wr_en_i && (wr_idx_i == PW'(g))) q <= wr_data_i;
        end
        assign slot[g] = q;
    end

    assign rd_data_o = slot[rd_idx_i];

endmodule

// File: rtl/ret_stack.sv
module ret_stack
    import ret_stack_pkg::*;
#(
    parameter int unsigned WIDTH = RS_WIDTH,
    parameter int unsigned DEPTH = RS_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] push_addr_i,
    output logic [WIDTH-1:0] tos_o
);

    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic          wr_en;
    logic [PW-1:0] wr_idx;
    logic [PW-1:0] rd_idx;
    logic [PW-1:0] ptr;

    ret_stack_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .push_i   (push_i),
        .pop_i    (pop_i),
        .wr_en_o  (wr_en),
        .wr_idx_o (wr_idx),
        .rd_idx_o (rd_idx),
        .ptr_o    (ptr)
    );

    ret_stack_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (push_addr_i),
        .rd_idx_i  (rd_idx),
        .rd_data_o (tos_o)
    );

endmodule

// File: rtl/ret_stack_chk.sv
module ret_stack_chk #(
    parameter int unsigned WIDTH = 13,
    parameter int unsigned PW    = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             push_i,
    input logic             pop_i,
    input logic [WIDTH-1:0] push_addr_i,
    input logic [WIDTH-1:0] tos_o,
    input logic [PW-1:0]    ptr
);

    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)              age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    AST_RESET_PTR: assert property (@(posedge clk)
        rst |=> ptr == '0); // R1

    AST_PUSH_TOP: assert property (@(posedge clk) disable iff (rst)
        push_i |=> tos_o === $past(push_addr_i)); // R2

    AST_PUSH_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        push_i |=> ptr == PW'($past(ptr) + 1'b1)); // R3

    AST_POP_RETREAT: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i) |=> ptr == PW'($past(ptr) - 1'b1)); // R4

    AST_PUSH_POP_UNDO: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3 && push_i && !pop_i) ##1 (pop_i && !push_i)
        |=> tos_o === $past(tos_o, 2)); // R4

    AST_BOTH_PUSH_WINS: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i) |=> (tos_o === $past(push_addr_i)) && (ptr == PW'($past(ptr) + 1'b1))); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!push_i && !pop_i) |=> (tos_o === $past(tos_o)) && (ptr == $past(ptr))); // R7

endmodule

bind ret_stack ret_stack_chk #(.WIDTH(WIDTH), .PW(PW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .push_addr_i (push_addr_i),
    .tos_o       (tos_o),
    .ptr         (ptr)
);

// File: tb/sim_ret_stack.sv
module sim_ret_stack;

    localparam int W = 13;
    localparam int D = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         push = 1'b0;
    logic         pop = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] tos;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [W-1:0] m_mem [D];
    bit           m_val [D];
    int           m_ptr = 0;

    always #5 clk = ~clk;

    ret_stack u0 (
        .clk(clk), .rst(rst), .push_i(push), .pop_i(pop),
        .push_addr_i(din), .tos_o(tos)
    );

    function automatic int below(input int p);
        return (p + D - 1) % D;
    endfunction

    task automatic check_top(input string tag);
        int s = below(m_ptr);
        if (m_val[s]) begin
            checks++;
            if (tos !== m_mem[s]) begin
                errors++;
                $display("FAIL %s: tos_o=%h expected=%h", tag, tos, m_mem[s]);
            end
        end
    endtask

    // drive at negedge, model at posedge, sample 2ns after
    task automatic step(input bit ps, input bit pp, input logic [W-1:0] d, input string tag);
        @(negedge clk);
        push = ps; pop = pp; din = d;
        @(posedge clk);
        if (ps) begin
            m_mem[m_ptr] = d; m_val[m_ptr] = 1'b1; m_ptr = (m_ptr + 1) % D;
        end else if (pp) begin
            m_ptr = below(m_ptr);
        end
        #2;
        push = 1'b0; pop = 1'b0;
        check_top(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        m_ptr = 0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < D; i++) m_val[i] = 1'b0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R3: nine pushes, then eight pops show first value lost
        for (int i = 0; i < 9; i++) step(1'b1, 1'b0, W'(13'h100 + i), "R2");
        for (int i = 0; i < 8; i++) step(1'b0, 1'b1, '0, "R3");
        checks++;
        if (tos !== W'(13'h108)) begin
            errors++;
            $display("FAIL R3: tos_o=%h expected=%h", tos, W'(13'h108));
        end
        // tenth push overwrites second pushed value (slot 1)
        step(1'b1, 1'b0, 13'h1AAA, "R3");
        step(1'b1, 1'b0, 13'h0BBB, "R3");
        checks++;
        if (tos !== 13'h0BBB) begin
            errors++;
            $display("FAIL R3: tos_o=%h expected=%h", tos, 13'h0BBB);
        end

        // R1: reset keeps contents, index returns to slot 0
        for (int i = 0; i < D; i++) step(1'b1, 1'b0, W'(13'h0A00 + 7 * i), "R2");
        do_reset();
        #2;
        checks++;
        if (tos !== m_mem[D-1]) begin
            errors++;
            $display("FAIL R1: tos_o=%h expected=%h", tos, m_mem[D-1]);
        end

        // R5: underflow wraps, returns stale entries
        step(1'b0, 1'b1, '0, "R5");
        step(1'b0, 1'b1, '0, "R5");
        step(1'b0, 1'b1, '0, "R5");

        // R6: simultaneous strobes act as push
        step(1'b1, 1'b1, 13'h1234, "R6");
        checks++;
        if (tos !== 13'h1234) begin
            errors++;
            $display("FAIL R6: tos_o=%h expected=%h", tos, 13'h1234);
        end
        step(1'b0, 1'b1, '0, "R6");

        // R7: idle cycles hold output
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, W'($urandom), "R7");

        // R4/R8: random mix
        for (int i = 0; i < 4000; i++) begin
            int r = int'($urandom % 10);
            bit ps = (r < 4) || (r == 9);
            bit pp = (r >= 4 && r < 8) || (r == 9);
            step(ps, pp, W'($urandom), ps ? (pp ? "R6" : "R2") : (pp ? "R4" : "R8"));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: tos_o=%h expected=completion", tos);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule